// File: doc/BRIEF.md
# Pending-Source ID Encoder

This block turns the pending state of a three-bank interrupt controller into the identity of the single source that software should service next. It reads a summary word and the pending words of two cascaded banks. The summary word carries eight basic sources, two cascade flags and a set of shortcut bits that mirror chosen bank sources. From these the block picks one winner by fixed group priority. Shortcut positions are mapped back to the real bit numbers of their banks. The result is a packed ID with a valid flag.

The choice is made combinationally and registered once, so the ID appears one clock after the inputs are sampled. A cascade flag set while its bank word is empty is an inconsistent state. The block reports it on an error output and gives no valid ID. The block holds no pending state and takes no acknowledge: it recomputes the ID on every cycle.

Top module: `pend_id_encoder`

## Requirements
- R1: While `rst_n` is low, `id_valid_o`, `cascade_err_o` and `id_o` are all zero.
- R2: Summary bits 21 to 31 are ignored. A summary word with only those bits set gives `id_valid_o` = 0 and `cascade_err_o` = 0.
- R3: When summary bits 0 to 20 are all zero, `id_valid_o` is 0 and `cascade_err_o` is 0.
- R4: When any of summary bits 0 to 7 is set, the lowest such bit wins over every other group. The ID is then bank 0 with that bit as the index.
- R5: Otherwise, if any of summary bits 10 to 14 is set, the lowest one wins. The ID is bank 1, and the index is taken in order from the list 7, 9, 10, 18, 19 (bit 10 gives 7, bit 14 gives 19).
- R6: Otherwise, if any of summary bits 15 to 20 is set, the lowest one wins. The ID is bank 2, and the index is taken in order from the list 21, 22, 23, 24, 25, 30 (bit 15 gives 21, bit 20 gives 30).
- R7: Otherwise, if summary bit 8 is set, the ID is bank 1 with the lowest set bit of `bank1_i` as the index. This group wins over summary bit 9.
- R8: Otherwise, if summary bit 9 is set, the ID is bank 2 with the lowest set bit of `bank2_i` as the index.
- R9: When the winning cascade bit (8, or 9 with bit 8 clear) has an all-zero bank word, `cascade_err_o` is 1 and `id_valid_o` is 0. In every other case `cascade_err_o` is 0.
- R10: `id_o` is packed as bank number in bits [6:5] and index in bits [4:0]. All outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| summary_i | input | 32 | Summary pending word |
| bank1_i | input | 32 | Pending word of cascaded bank 1 |
| bank2_i | input | 32 | Pending word of cascaded bank 2 |
| id_valid_o | output | 1 | The ID is meaningful |
| id_o | output | 7 | Packed ID: bank [6:5], index [4:0] |
| cascade_err_o | output | 1 | Cascade flag set with an empty bank word |

## Verification
The bench drives summary words that set bits in several groups at once, so that each group is shown to lose to the group above it. It covers both edge entries of each shortcut list, which exposes a wrong or shifted lookup. Bank words with a single high bit and with several bits set tell the cascade path's lowest-bit rule apart from a highest-bit rule. The bench also drives empty summaries, summaries with only masked-out bits set, and empty bank words behind a set cascade flag. These separate the plain idle case from the error case.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 5;
  localparam int BANK_W   = 2;
  localparam int ID_W     = BANK_W + IDX_W;
  localparam int BASIC_N  = 8;
  localparam int CASC1_B  = 8;
  localparam int CASC2_B  = 9;
  localparam int SC_LO    = 10;
  localparam int SC1_N    = 5;
  localparam int SC2_N    = 6;
  localparam int SC_N     = SC1_N + SC2_N;
  localparam int NBANKS   = 2;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [BANK_W-1:0] {
    BANK_BASIC = 2'd0,
    BANK_ONE   = 2'd1,
    BANK_TWO   = 2'd2
  } bank_e;

  // true source numbers behind each shortcut position, bank 1 list then bank 2 list
  localparam idx_t SC_MAP [SC_N] = '{
    5'd7, 5'd9, 5'd10, 5'd18, 5'd19,
    5'd21, 5'd22, 5'd23, 5'd24, 5'd25, 5'd30
  };

  localparam logic [WORD_W-1:0] VALID_MASK =
    WORD_W'((64'd1 << (SC_LO + SC_N)) - 64'd1);
endpackage

// File: rtl/lsb_pick.sv
module lsb_pick #(
  parameter int W  = 8,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
    hit_o = |vec_i;
  end
endmodule

// File: rtl/shortcut_remap.sv
module shortcut_remap
  import pie_pkg::*;
#(
  parameter int P1W = 3,
  parameter int P2W = 3
) (
  input  logic [P1W-1:0] pos1_i,
  input  logic [P2W-1:0] pos2_i,
  output idx_t           src1_o,
  output idx_t           src2_o
);
  int sel1;
  int sel2;

  always_comb begin
    sel1 = int'(pos1_i);
    sel2 = SC1_N + int'(pos2_i);
    src1_o = (sel1 < SC1_N) ? SC_MAP[sel1] : '0;
    src2_o = (sel2 < SC_N)  ? SC_MAP[sel2] : '0;
  end
endmodule

// File: rtl/pend_id_encoder.sv
module pend_id_encoder
  import pie_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] summary_i,
  input  logic [WORD_W-1:0] bank1_i,
  input  logic [WORD_W-1:0] bank2_i,
  output logic              id_valid_o,
  output logic [ID_W-1:0]   id_o,
  output logic              cascade_err_o
);
  localparam int BPW = $clog2(BASIC_N);
  localparam int S1W = $clog2(SC1_N);
  localparam int S2W = $clog2(SC2_N);

  logic [WORD_W-1:0] masked;
  logic              none_pend;

  logic           basic_hit, sc1_hit, sc2_hit;
  logic [BPW-1:0] basic_pos;
  logic [S1W-1:0] sc1_pos;
  logic [S2W-1:0] sc2_pos;
  idx_t           sc1_src, sc2_src;

  logic [WORD_W-1:0] bank_word [NBANKS];
  logic              bank_hit  [NBANKS];
  idx_t              bank_pos  [NBANKS];

  logic            nxt_valid, nxt_err;
  bank_e           nxt_bank;
  idx_t            nxt_idx;
  logic [ID_W-1:0] nxt_id;
  logic            upd_en;

  assign masked    = summary_i & VALID_MASK;
  assign none_pend = (masked == '0);
  assign upd_en    = 1'b1;

  lsb_pick #(.W(BASIC_N), .PW(BPW)) u_basic (
    .vec_i(masked[BASIC_N-1:0]), .hit_o(basic_hit), .pos_o(basic_pos));
  lsb_pick #(.W(SC1_N), .PW(S1W)) u_sc1 (
    .vec_i(masked[SC_LO+SC1_N-1:SC_LO]), .hit_o(sc1_hit), .pos_o(sc1_pos));
  lsb_pick #(.W(SC2_N), .PW(S2W)) u_sc2 (
    .vec_i(masked[SC_LO+SC_N-1:SC_LO+SC1_N]), .hit_o(sc2_hit), .pos_o(sc2_pos));

  shortcut_remap #(.P1W(S1W), .P2W(S2W)) u_remap (
    .pos1_i(sc1_pos), .pos2_i(sc2_pos), .src1_o(sc1_src), .src2_o(sc2_src));

  assign bank_word[0] = bank1_i;
  assign bank_word[1] = bank2_i;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    lsb_pick #(.W(WORD_W), .PW(IDX_W)) u_bank (
      .vec_i(bank_word[b]), .hit_o(bank_hit[b]), .pos_o(bank_pos[b]));
  end

  // next-state: group priority basic > shortcut1 > shortcut2 > cascade1 > cascade2
  always_comb begin
    nxt_valid = 1'b0;
    nxt_err   = 1'b0;
    nxt_bank  = BANK_BASIC;
    nxt_idx   = '0;
    if (none_pend) begin
      nxt_valid = 1'b0;
    end else if (basic_hit) begin
      nxt_valid = 1'b1;
      nxt_idx   = idx_t'(basic_pos);
    end else if (sc1_hit) begin
      nxt_valid = 1'b1;
      nxt_bank  = BANK_ONE;
      nxt_idx   = sc1_src;
    end else if (sc2_hit) begin
      nxt_valid = 1'b1;
      nxt_bank  = BANK_TWO;
      nxt_idx   = sc2_src;
    end else if (masked[CASC1_B]) begin
      nxt_bank  = BANK_ONE;
      nxt_valid = bank_hit[0];
      nxt_err   = !bank_hit[0];
      nxt_idx   = bank_pos[0];
    end else if (masked[CASC2_B]) begin
      nxt_bank  = BANK_TWO;
      nxt_valid = bank_hit[1];
      nxt_err   = !bank_hit[1];
      nxt_idx   = bank_pos[1];
    end
    nxt_id = {nxt_bank, nxt_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid_o    <= 1'b0;
      cascade_err_o <= 1'b0;
      id_o          <= '0;
    end else if (upd_en) begin
      id_valid_o    <= nxt_valid;
      cascade_err_o <= nxt_err;
      id_o          <= nxt_id;
    end
  end
endmodule

// File: rtl/pie_checker.sv
module pie_checker
  import pie_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] summary_i,
  input logic [WORD_W-1:0] bank1_i,
  input logic              id_valid_o,
  input logic [ID_W-1:0]   id_o,
  input logic              cascade_err_o
);
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!id_valid_o && !cascade_err_o && id_o == '0);
    end
  end

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((summary_i & VALID_MASK) == '0) |=> (!id_valid_o && !cascade_err_o));

  p_basic_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_i[BASIC_N-1:0] != '0) |=> (id_valid_o && id_o[ID_W-1:IDX_W] == 2'd0));

  p_sc2_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_i[BASIC_N-1:0] == '0 && summary_i[SC_LO+SC1_N-1:SC_LO] == '0 &&
     summary_i[SC_LO+SC_N-1:SC_LO+SC1_N] != '0)
    |=> (id_valid_o && id_o[ID_W-1:IDX_W] == 2'd2));

  p_casc_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_i[CASC1_B] && summary_i[BASIC_N-1:0] == '0 &&
     summary_i[SC_LO+SC_N-1:SC_LO] == '0 && bank1_i == '0)
    |=> (cascade_err_o && !id_valid_o));

  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cascade_err_o && id_valid_o));
endmodule

bind pend_id_encoder pie_checker chk_i (
  .clk(clk), .rst_n(rst_n), .summary_i(summary_i), .bank1_i(bank1_i),
  .id_valid_o(id_valid_o), .id_o(id_o), .cascade_err_o(cascade_err_o));

// File: tb/pend_id_encoder_tb_top.sv
module pend_id_encoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] summary_i, bank1_i, bank2_i;
  logic        id_valid_o, cascade_err_o;
  logic [6:0]  id_o;

  typedef struct {
    logic       v;
    logic       e;
    logic [6:0] id;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  pend_id_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .summary_i(summary_i), .bank1_i(bank1_i),
    .bank2_i(bank2_i), .id_valid_o(id_valid_o), .id_o(id_o),
    .cascade_err_o(cascade_err_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int low_bit(input logic [31:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (w[i]) return i;
    return -1;
  endfunction

  function automatic logic [4:0] sc_src(input int k);
    case (k)
      0: return 5'd7;   1: return 5'd9;   2: return 5'd10;
      3: return 5'd18;  4: return 5'd19;  5: return 5'd21;
      6: return 5'd22;  7: return 5'd23;  8: return 5'd24;
      9: return 5'd25;  default: return 5'd30;
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] s, input logic [31:0] b1,
                                 input logic [31:0] b2, input string tag);
    exp_t r;
    int k;
    r.v = 0; r.e = 0; r.id = '0; r.tag = tag;
    if ((k = low_bit(s, 0, 7)) >= 0) begin
      r.v = 1; r.id = {2'd0, 5'(k)};
    end else if ((k = low_bit(s, 10, 20)) >= 0) begin
      r.v = 1; r.id = {(k < 15) ? 2'd1 : 2'd2, sc_src(k - 10)};
    end else if (s[8]) begin
      k = low_bit(b1, 0, 31);
      if (k < 0) r.e = 1; else begin r.v = 1; r.id = {2'd1, 5'(k)}; end
    end else if (s[9]) begin
      k = low_bit(b2, 0, 31);
      if (k < 0) r.e = 1; else begin r.v = 1; r.id = {2'd2, 5'(k)}; end
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] s, input logic [31:0] b1,
                       input logic [31:0] b2, input string tag);
    @(negedge clk);
    summary_i = s; bank1_i = b1; bank2_i = b2;
    exp_q.push_back(model(s, b1, b2, tag));
  endtask

  task automatic drive_hand(input logic [31:0] s, input logic [31:0] b1,
                            input logic [31:0] b2, input logic v, input logic e,
                            input logic [6:0] id, input string tag);
    exp_t r;
    @(negedge clk);
    summary_i = s; bank1_i = b1; bank2_i = b2;
    r.v = v; r.e = e; r.id = id; r.tag = tag;
    exp_q.push_back(r);
  endtask

  // monitor: compare one queued item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        checks++;
        if (id_valid_o !== x.v || cascade_err_o !== x.e || (x.v && id_o !== x.id)) begin
          errors++;
          $display("FAIL %s: got v=%0b e=%0b id=0x%02h, expected v=%0b e=%0b id=0x%02h",
                   x.tag, id_valid_o, cascade_err_o, id_o, x.v, x.e, x.id);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    summary_i = 32'h0000_01FF; bank1_i = 32'h1; bank2_i = 32'h1;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (id_valid_o !== 1'b0 || cascade_err_o !== 1'b0 || id_o !== 7'd0) begin
      errors++;
      $display("FAIL R1: got v=%0b e=%0b id=0x%02h, expected 0 0 0x00",
               id_valid_o, cascade_err_o, id_o);
    end
    rst_n = 1'b1;
    summary_i = '0;

    drive_hand(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 7'd0, "R3 idle");
    drive_hand(32'hFFE0_0000, 32'h4, 32'h4, 0, 0, 7'd0, "R2 high bits masked");
    drive_hand(32'h001F_FFA4, 32'h1, 32'h1, 1, 0, {2'd0, 5'd2}, "R4 basic lowest");
    drive_hand(32'h0000_0080, 32'h0, 32'h0, 1, 0, {2'd0, 5'd7}, "R4 basic top bit");
    drive_hand(32'h0001_1300, 32'h1, 32'h1, 1, 0, {2'd1, 5'd10}, "R5 sc1 over sc2 and cascade");
    drive_hand(32'h0000_0400, 32'h0, 32'h0, 1, 0, {2'd1, 5'd7}, "R5 sc1 first entry");
    drive_hand(32'h0000_4000, 32'h0, 32'h0, 1, 0, {2'd1, 5'd19}, "R5 sc1 last entry");
    drive_hand(32'h0010_0300, 32'h1, 32'h1, 1, 0, {2'd2, 5'd30}, "R6 sc2 last entry");
    drive_hand(32'h0000_8000, 32'h0, 32'h0, 1, 0, {2'd2, 5'd21}, "R6 sc2 first entry");
    drive_hand(32'h0000_0300, 32'h8001_0000, 32'h1, 1, 0, {2'd1, 5'd16}, "R7 cascade1 lowest");
    drive_hand(32'h0000_0200, 32'h0, 32'h8000_0000, 1, 0, {2'd2, 5'd31}, "R8 cascade2 top bit");
    drive_hand(32'h0000_0300, 32'h0, 32'hF0, 0, 1, 7'd0, "R9 cascade1 empty");
    drive_hand(32'h0000_0200, 32'h0, 32'h0, 0, 1, 7'd0, "R9 cascade2 empty");
    drive_hand(32'h0000_0001, 32'h0, 32'h0, 1, 0, {2'd0, 5'd0}, "R9 error clears");
    // R10: alternating words expose any extra or missing pipeline stage
    for (int i = 0; i < 8; i++) begin
      drive(32'h1 << (i * 3 % 21), 32'h1 << i, 32'h1 << (31 - i), "R10 back-to-back");
    end
    for (int i = 0; i < 200; i++) begin
      logic [31:0] s;
      s = (32'h1 << (i % 32)) | (32'h100 << (i % 2)) ;
      if (i % 5 == 0) s = 32'h0000_0300 | (32'h1 << (21 + i % 11));
      drive(s, (i % 7 == 0) ? 32'h0 : (32'hFFFF_FFFF << (i % 32)),
            (i % 3 == 0) ? 32'h0 : (32'h1 << (i % 29)), "R10 sweep");
    end
    drive(32'h0, 32'h0, 32'h0, "R3 final idle");
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule